// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the register front end of a 16x-oversampling serial port that has 32-byte transmit and receive queues. It sits on a simple word-addressed 32-bit bus with one select, one write flag, a byte offset and separate write and read data. It holds the divisor, the character-length code, the queue enable and an interrupt-enable byte. It pulses the queue clear lines. It gathers the busy and queue flags into two read-only status words. It also turns data-offset accesses into push and pop strobes for the queues.

Two offsets are banked. A latch bit in the line-control word decides where offsets 0x00 and 0x04 go. With the bit set they reach the low and high divisor bytes. With the bit clear they reach the transmit/receive data path and the interrupt-enable byte. The queues and the shifters are outside this block. They connect through plain strobe and flag ports.

Top module: `uart_regbank`

## Requirements
- R1: After reset the divisor is 0, the character-length code is 0, the queue enable is 0, and both the line-control word (offset 0x0C) and the interrupt-enable byte read as 0.
- R2: A write to offset 0x0C stores bit 7 as the bank latch and bits [1:0] as the character-length code on `char_len` (0, 1, 2 and 3 mean 5, 6, 7 and 8 bits). A read returns only those bits, and all other bits read 0.
- R3: While the latch is set, offsets 0x00 and 0x04 write and read bits [7:0] and [15:8] of `divisor`. Such accesses never raise `tx_push` or `rx_pop`. The divisor changes only through these writes.
- R4: While the latch is clear, a write to 0x00 raises `tx_push` in that cycle with `tx_data` equal to write-data bits [7:0], unless `tx_full` is high. If `tx_full` is high the write is dropped and no push is made.
- R5: While the latch is clear, a read of 0x00 with `rx_empty` low raises `rx_pop` and returns `rx_data` in bits [7:0] with zeros above. With `rx_empty` high the read returns 0 and does not pop.
- R6: While the latch is clear, offset 0x04 is an 8-bit interrupt-enable byte that reads back what was written in bits [7:0].
- R7: At offset 0x08, write bit 0 sets `fifo_en`. A read returns `fifo_en` in bit 0 and zeros elsewhere.
- R8: A write to 0x08 with bit 1 set raises `rx_clr`, and one with bit 2 set raises `tx_clr`. Each pulse lasts exactly the one cycle after the write. Both bits read back as 0.
- R9: Offset 0x7C reads {rx_full, not rx_empty, tx_empty, not tx_full, busy} in bits [4:0], with zeros above. Writes to it change nothing.
- R10: Offset 0x14 reads not rx_empty in bit 0, not tx_full in bit 5, and (tx_empty and not busy) in bit 6, with zeros elsewhere. Writes to it change nothing.
- R11: Any other offset reads as 0 and ignores writes.
- R12: Read data appears on `bus_rdata` in the cycle after the read is presented. It is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| divisor | output | 16 | Baud divisor |
| char_len | output | 2 | Character-length code |
| fifo_en | output | 1 | Queue enable |
| rx_clr | output | 1 | One-cycle receive queue clear |
| tx_clr | output | 1 | One-cycle transmit queue clear |
| tx_push | output | 1 | Push strobe to transmit queue |
| tx_data | output | 8 | Byte to push |
| tx_full | input | 1 | Transmit queue full |
| tx_empty | input | 1 | Transmit queue empty |
| rx_pop | output | 1 | Pop strobe to receive queue |
| rx_data | input | 8 | Head byte of receive queue |
| rx_empty | input | 1 | Receive queue empty |
| rx_full | input | 1 | Receive queue full |
| busy | input | 1 | Serial engine active |

## Verification
The hardest case to reach is a data-offset access made while the bank latch is set and the receive queue holds data. There a wrong decode would pop a byte or push one instead of touching the divisor. The stimulus first sets the latch and forces `rx_empty` low. It then sweeps divisor values through both banked offsets and reads each back, checking the strobes in the same cycle. After that it clears the latch and repeats the data accesses against full, empty and mixed queue flags, including all 32 flag combinations for the status words.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int BUS_W       = 32;
    localparam int OFS_SHARED0 = 'h00;
    localparam int OFS_SHARED1 = 'h04;
    localparam int OFS_FCTL    = 'h08;
    localparam int OFS_LCTL    = 'h0C;
    localparam int OFS_LSTAT   = 'h14;
    localparam int OFS_STAT    = 'h7C;

    // one flag per register target of an access
    typedef struct packed {
        logic data;
        logic ier;
        logic dll;
        logic dlh;
        logic fctl;
        logic lctl;
        logic lstat;
        logic stat;
    } hit_t;

    typedef struct packed {
        logic             dlab;
        logic [1:0]       dls;
        logic [15:0]      div;
        logic [7:0]       ier;
        logic             fifo_en;
        logic             rx_clr;
        logic             tx_clr;
        logic [BUS_W-1:0] rdata;
    } regs_t;

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dlab,
    output hit_t              hit
);

    always_comb begin
        hit = '0;
        if (addr == ADDR_W'(OFS_SHARED0)) begin
            hit.data = !dlab;
            hit.dll  = dlab;
        end
        if (addr == ADDR_W'(OFS_SHARED1)) begin
            hit.ier  = !dlab;
            hit.dlh  = dlab;
        end
        hit.fctl  = (addr == ADDR_W'(OFS_FCTL));
        hit.lctl  = (addr == ADDR_W'(OFS_LCTL));
        hit.lstat = (addr == ADDR_W'(OFS_LSTAT));
        hit.stat  = (addr == ADDR_W'(OFS_STAT));
    end

endmodule

// File: rtl/uart_regbank_status.sv
module uart_regbank_status
    import uart_regbank_pkg::*;
(
    input  logic             busy,
    input  logic             tx_full,
    input  logic             tx_empty,
    input  logic             rx_empty,
    input  logic             rx_full,
    output logic [BUS_W-1:0] stat_word,
    output logic [BUS_W-1:0] lstat_word
);

    always_comb begin
        stat_word     = '0;
        stat_word[0]  = busy;
        stat_word[1]  = !tx_full;
        stat_word[2]  = tx_empty;
        stat_word[3]  = !rx_empty;
        stat_word[4]  = rx_full;
        lstat_word    = '0;
        lstat_word[0] = !rx_empty;
        lstat_word[5] = !tx_full;
        lstat_word[6] = tx_empty && !busy;
    end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [15:0]       divisor,
    output logic [1:0]        char_len,
    output logic              fifo_en,
    output logic              rx_clr,
    output logic              tx_clr,
    output logic              tx_push,
    output logic [7:0]        tx_data,
    input  logic              tx_full,
    input  logic              tx_empty,
    output logic              rx_pop,
    input  logic [7:0]        rx_data,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              busy
);

    regs_t            r_d, r_q;
    hit_t             hit;
    logic             dlab;
    logic             wr_en, rd_en;
    logic [BUS_W-1:0] stat_word, lstat_word;

    assign dlab  = r_q.dlab;
    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    uart_regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .dlab (dlab),
        .hit  (hit)
    );

    uart_regbank_status u_status (
        .busy       (busy),
        .tx_full    (tx_full),
        .tx_empty   (tx_empty),
        .rx_empty   (rx_empty),
        .rx_full    (rx_full),
        .stat_word  (stat_word),
        .lstat_word (lstat_word)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rx_clr = 1'b0;
        r_d.tx_clr = 1'b0;
        r_d.rdata  = '0;
        if (wr_en) begin
            if (hit.lctl) begin
                r_d.dlab = bus_wdata[7];
                r_d.dls  = bus_wdata[1:0];
            end
            if (hit.dll)  r_d.div[7:0]  = bus_wdata[7:0];
            if (hit.dlh)  r_d.div[15:8] = bus_wdata[7:0];
            if (hit.ier)  r_d.ier       = bus_wdata[7:0];
            if (hit.fctl) begin
                r_d.fifo_en = bus_wdata[0];
                r_d.rx_clr  = bus_wdata[1];
                r_d.tx_clr  = bus_wdata[2];
            end
        end
        if (rd_en) begin
            if (hit.data && !rx_empty) r_d.rdata = BUS_W'(rx_data);
            if (hit.dll)   r_d.rdata = BUS_W'(r_q.div[7:0]);
            if (hit.dlh)   r_d.rdata = BUS_W'(r_q.div[15:8]);
            if (hit.ier)   r_d.rdata = BUS_W'(r_q.ier);
            if (hit.fctl)  r_d.rdata = BUS_W'(r_q.fifo_en);
            if (hit.lctl)  r_d.rdata = BUS_W'({r_q.dlab, 5'b0, r_q.dls});
            if (hit.lstat) r_d.rdata = lstat_word;
            if (hit.stat)  r_d.rdata = stat_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_push   = wr_en && hit.data && !tx_full;
    assign tx_data   = bus_wdata[7:0];
    assign rx_pop    = rd_en && hit.data && !rx_empty;
    assign bus_rdata = r_q.rdata;
    assign divisor   = r_q.div;
    assign char_len  = r_q.dls;
    assign fifo_en   = r_q.fifo_en;
    assign rx_clr    = r_q.rx_clr;
    assign tx_clr    = r_q.tx_clr;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [15:0]       divisor,
    input logic              rx_clr,
    input logic              tx_clr,
    input logic              tx_push,
    input logic              tx_full,
    input logic              rx_pop,
    input logic              rx_empty,
    input logic              dlab
);

    logic mapped;
    always_comb begin
        mapped = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04)) ||
                 (bus_addr == ADDR_W'('h08)) || (bus_addr == ADDR_W'('h0C)) ||
                 (bus_addr == ADDR_W'('h14)) || (bus_addr == ADDR_W'('h7C));
    end

    a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full);

    a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty);

    a_r3_no_queue_access_banked: assert property (@(posedge clk) disable iff (!rst_n)
        dlab |-> (!tx_push && !rx_pop));

    a_r3_divisor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && bus_wr) |-> $stable(divisor));

    a_r8_rx_clr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'('h08)));

    a_r8_tx_clr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'('h08)));

    a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && !bus_wr && !mapped) |-> (bus_rdata == 32'd0));

    a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && !bus_wr) |-> (bus_rdata == 32'd0));

endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .divisor   (divisor),
    .rx_clr    (rx_clr),
    .tx_clr    (tx_clr),
    .tx_push   (tx_push),
    .tx_full   (tx_full),
    .rx_pop    (rx_pop),
    .rx_empty  (rx_empty),
    .dlab      (dlab)
);

// File: tb/test_uart_regbank.sv
module test_uart_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] divisor;
    logic [1:0]  char_len;
    logic        fifo_en, rx_clr, tx_clr, tx_push, rx_pop;
    logic [7:0]  tx_data;
    logic        tx_full = 1'b0;
    logic        tx_empty = 1'b1;
    logic [7:0]  rx_data = 8'hA5;
    logic        rx_empty = 1'b1;
    logic        rx_full = 1'b0;
    logic        busy = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    logic        s_push, s_pop, s_rxclr, s_txclr;
    logic [7:0]  s_txd;
    logic [31:0] s_rd;
    logic [15:0] exp_div;

    always #4 clk = ~clk;

    uart_regbank i_uart_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .divisor(divisor), .char_len(char_len), .fifo_en(fifo_en),
        .rx_clr(rx_clr), .tx_clr(tx_clr), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_empty(rx_empty), .rx_full(rx_full), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        s_push = tx_push; s_txd = tx_data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        s_rxclr = rx_clr; s_txclr = tx_clr;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        s_pop = rx_pop; s_push = tx_push;
        @(negedge clk);
        bus_sel = 1'b0;
        s_rd = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 divisor", 32'(divisor), 0);
        check("R1 char_len", 32'(char_len), 0);
        check("R1 fifo_en", 32'(fifo_en), 0);
        check("R1 rdata", bus_rdata, 0);
        bus_read(8'h0C); check("R1 line control", s_rd, 0);
        bus_read(8'h04); check("R1 interrupt enable", s_rd, 0);

        // R2 character length sweep; bits 6:2 and upper bits must not stick
        for (int k = 0; k < 4; k++) begin
            bus_write(8'h0C, 32'hFFFF_FF7C | 32'(k));
            check("R2 char_len", 32'(char_len), 32'(k));
            bus_read(8'h0C); check("R2 readback", s_rd, 32'(k));
        end

        // R3 banked divisor sweep with data waiting in receive queue
        bus_write(8'h0C, 32'h83);
        rx_empty = 1'b0; rx_data = 8'h3C;
        for (int k = 0; k < 16; k++) begin
            exp_div = 16'(k * 4099 + 7);
            bus_write(8'h00, {24'hDEADBE, exp_div[7:0]});
            check("R3 no push when banked", 32'(s_push), 0);
            bus_write(8'h04, {24'h123456, exp_div[15:8]});
            check("R3 divisor value", 32'(divisor), 32'(exp_div));
            bus_read(8'h00);
            check("R3 low byte read", s_rd, 32'(exp_div[7:0]));
            check("R3 no pop when banked", 32'(s_pop), 0);
            bus_read(8'h04);
            check("R3 high byte read", s_rd, 32'(exp_div[15:8]));
        end
        rx_empty = 1'b1;
        bus_write(8'h0C, 32'h03);
        check("R3 divisor kept after unbank", 32'(divisor), 32'(exp_div));

        // R4 transmit pushes
        for (int b = 0; b < 256; b += 17) begin
            bus_write(8'h00, {24'hABCDEF, 8'(b)});
            check("R4 push", 32'(s_push), 1);
            check("R4 tx_data", 32'(s_txd), 32'(b));
        end
        tx_full = 1'b1;
        bus_write(8'h00, 32'h55);
        check("R4 dropped when full", 32'(s_push), 0);
        check("R4 divisor untouched", 32'(divisor), 32'(exp_div));
        tx_full = 1'b0;

        // R5 receive pops
        rx_empty = 1'b0;
        for (int b = 1; b < 256; b += 37) begin
            rx_data = 8'(b);
            bus_read(8'h00);
            check("R5 pop", 32'(s_pop), 1);
            check("R5 rx byte", s_rd, 32'(b));
        end
        rx_empty = 1'b1; rx_data = 8'hFF;
        bus_read(8'h00);
        check("R5 empty read pop", 32'(s_pop), 0);
        check("R5 empty read value", s_rd, 0);
        // R12 idle cycle after read
        @(negedge clk);
        check("R12 idle rdata", bus_rdata, 0);

        // R6 interrupt enable
        bus_write(8'h04, 32'hFFFF_FF5A);
        bus_read(8'h04); check("R6 ier readback", s_rd, 32'h5A);
        check("R6 divisor untouched", 32'(divisor), 32'(exp_div));

        // R7 / R8 queue control
        bus_write(8'h08, 32'h7);
        check("R7 fifo_en", 32'(fifo_en), 1);
        check("R8 rx_clr pulse", 32'(s_rxclr), 1);
        check("R8 tx_clr pulse", 32'(s_txclr), 1);
        @(negedge clk);
        check("R8 rx_clr one cycle", 32'(rx_clr), 0);
        check("R8 tx_clr one cycle", 32'(tx_clr), 0);
        bus_read(8'h08); check("R8 clear bits read 0", s_rd, 1);
        bus_write(8'h08, 32'h2);
        check("R8 rx only", 32'({s_rxclr, s_txclr}), 2);
        check("R7 fifo_en off", 32'(fifo_en), 0);
        bus_write(8'h08, 32'h4);
        check("R8 tx only", 32'({s_rxclr, s_txclr}), 1);
        bus_write(8'h08, 32'h1);
        check("R8 none", 32'({s_rxclr, s_txclr}), 0);

        // R9 / R10 status sweep over every flag combination
        for (int m = 0; m < 32; m++) begin
            busy = m[0]; tx_full = m[1]; tx_empty = m[2]; rx_empty = m[3]; rx_full = m[4];
            bus_read(8'h7C);
            check("R9 status word", s_rd,
                  {27'd0, m[4], !m[3], m[2], !m[1], m[0]});
            bus_read(8'h14);
            check("R10 line status", s_rd,
                  32'({(m[2] && !m[0]), !m[1], 4'd0, !m[3]}));
        end
        busy = 0; tx_full = 0; tx_empty = 1; rx_empty = 1; rx_full = 0;
        bus_write(8'h7C, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h7C); check("R9 read-only", s_rd, 32'h6);
        bus_read(8'h14); check("R10 read-only", s_rd, 32'h60);
        check("R9 R10 no side effect", {divisor, 6'd0, char_len, 7'd0, fifo_en},
              {exp_div, 6'd0, 2'd3, 7'd0, 1'b1});

        // R11 unmapped offsets
        for (int u = 0; u < 7; u++) begin
            logic [7:0] a;
            case (u)
                0: a = 8'h10; 1: a = 8'h18; 2: a = 8'h20; 3: a = 8'h40;
                4: a = 8'h78; 5: a = 8'h80; default: a = 8'hFC;
            endcase
            bus_write(a, 32'hFFFF_FFFF);
            check("R11 no push", 32'(s_push), 0);
            bus_read(a);
            check("R11 reads zero", s_rd, 0);
        end
        check("R11 divisor kept", 32'(divisor), 32'(exp_div));
        check("R11 char_len kept", 32'(char_len), 3);
        check("R11 fifo_en kept", 32'(fifo_en), 1);
        bus_read(8'h04); check("R11 ier kept", s_rd, 32'h5A);
        bus_read(8'h0C); check("R11 line control kept", s_rd, 32'h3);

        finish_run();
    end

endmodule